// File: doc/BRIEF.md
# Return Instruction Sequencer with Register-Stack Refill

This block carries out the return-from-subprogram instruction of a processor whose local registers are a window onto a stack in memory. When `start` is high with a return encoding, it captures a source register pair and builds a new program counter and a new status word from it. It checks whether the change of privilege flags is allowed. The updated values stay on the `pcOut` and `srOut` outputs for the trap logic to use.

After the update it works out how far the frame pointer lies below the on-chip stack window. If there is a gap, the block refills the local registers from memory one word per memory transaction. The stack pointer walks down one word at a time until the gap is closed. A single-cycle `done` pulse, together with `trap`, ends each return. Encodings that share the opcode but do not name the program counter as destination are move double-word operations, and the block leaves them alone.

Top module: `ret_unit`

## Requirements
- R1: The instruction word holds the opcode 6'b000001 in bits 15..10, the destination set bit in bit 9, the source set bit in bit 8, the destination code in bits 7..4 and the source code in bits 3..0. `pairIdx` is {bit 8, bits 3..0}: set bit 1 means a local register and 0 means a global one.
- R2: A start with the opcode, bit 9 = 0 and destination code 0 (the program counter) begins a return. Any other word, including the same opcode with another destination, leaves `busy` and `done` low and the outputs unchanged.
- R3: `pcOut` becomes `regHi` with bit 0 cleared.
- R4: `srOut` becomes `regLo` with two changes: bit 18 (S) is replaced by `regHi[0]`, and bits 20..19 (instruction length) are cleared.
- R5: `trap` is raised together with `done` when (curS=0 and new S=1), or when (new S=0 and curL=0 and new L=1). New L is `regLo[15]`. On a trap no refill takes place and `spOut` keeps `spIn`.
- R6: The difference d = `fpIn` - `spIn[8:2]` is taken modulo 128 and read as signed 7-bit. If d >= 0, no memory read is made and `done` rises two cycles after the issuing edge.
- R7: If d < 0, exactly -d refill steps run. Each step requests address `spOut`-4, holds `memReqValid` until `memReqReady`, writes the response into local register (`spOut`-4)[7:2] through `lregWe`/`lregIdx`/`lregData`, and lowers `spOut` by 4.
- R8: `done` is a one-cycle pulse. With ready always high and a response one cycle after acceptance, it comes 2+2·(-d) cycles after the issuing edge. `busy` is high from the edge after issue through the `done` cycle.
- R9: After reset, `busy`, `done`, `trap`, `memReqValid` and `lregWe` are low, and `pcOut`, `srOut` and `spOut` are zero.
- R10: A start while `busy` is high is ignored. It does not change the running return's results and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction issue strobe |
| instr | input | 16 | Instruction word |
| pairIdx | output | 5 | Source pair index {set bit, code} |
| regHi | input | 32 | First register of the source pair |
| regLo | input | 32 | Second register of the source pair |
| curS | input | 1 | Current supervisor flag |
| curL | input | 1 | Current L flag |
| fpIn | input | 7 | Current frame pointer |
| spIn | input | 32 | Current stack pointer |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts request |
| memAddr | output | 32 | Memory read address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| lregWe | output | 1 | Local register write enable |
| lregIdx | output | 6 | Local register index |
| lregData | output | 32 | Local register write data |
| pcOut | output | 32 | Restored program counter |
| srOut | output | 32 | Restored status word |
| spOut | output | 32 | Stack pointer after refill |
| busy | output | 1 | Return in progress |
| done | output | 1 | Return finished (one cycle) |
| trap | output | 1 | Privilege error, valid with done |

## Verification
Each return's results are due in the `done` cycle. That cycle is two cycles after the issuing edge with no refill, plus two cycles for each refilled word, because the bench memory accepts requests at once and answers on the next cycle. The driver stores the expected `done` cycle with the expected PC, status, stack pointer and trap. The monitor samples on the falling edge, pops the item when `done` is seen and compares every field, including the observed latency. The local register contents, collected from the write port, are compared against a model of the refill at the same point.

// File: rtl/ret_pkg.sv
package ret_pkg;
  localparam logic [5:0] RET_OPC = 6'b000001;
  localparam logic [3:0] PC_CODE = 4'd0;

  typedef struct packed {
    logic load;   // capture pair, flags and difference
    logic step;   // one refill word written
  } strobe_t;

  typedef struct packed {
    logic isRet;
    logic trap;
    logic neg;
    logic last;
  } status_t;
endpackage

// File: rtl/ret_dpath.sv
module ret_dpath
  import ret_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int DIFFW   = 7,
  parameter int S_BIT   = 18,
  parameter int L_BIT   = 15,
  parameter int ILC_LSB = 19
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        instr,
  input  logic [XLEN-1:0]    regHi,
  input  logic [XLEN-1:0]    regLo,
  input  logic               curS,
  input  logic               curL,
  input  logic [DIFFW-1:0]   fpIn,
  input  logic [XLEN-1:0]    spIn,
  input  strobe_t            stb,
  input  logic [XLEN-1:0]    memRspData,
  output status_t            stat,
  output logic [4:0]         pairIdx,
  output logic [XLEN-1:0]    pcOut,
  output logic [XLEN-1:0]    srOut,
  output logic [XLEN-1:0]    spOut,
  output logic [XLEN-1:0]    memAddr,
  output logic [DIFFW-2:0]   lregIdx,
  output logic [XLEN-1:0]    lregData
);
  localparam int IDXW = DIFFW - 1;

  logic [XLEN-1:0]  pcR, srR, spR, newSr;
  logic [DIFFW-1:0] diffR, diffNew;
  logic             trapR, trapNew, newS, newL;

  // decode
  assign pairIdx    = {instr[8], instr[3:0]};
  assign stat.isRet = (instr[15:10] == RET_OPC) && !instr[9] && (instr[7:4] == PC_CODE);

  // new status word and privilege check
  always_comb begin
    newSr                = regLo;
    newSr[S_BIT]         = regHi[0];
    newSr[ILC_LSB +: 2]  = 2'b00;
  end
  assign newS    = regHi[0];
  assign newL    = regLo[L_BIT];
  assign trapNew = (!curS && newS) || (!newS && !curL && newL);
  assign diffNew = fpIn - spIn[DIFFW+1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcR   <= '0;
      srR   <= '0;
      spR   <= '0;
      diffR <= '0;
      trapR <= 1'b0;
    end else if (stb.load) begin
      pcR   <= {regHi[XLEN-1:1], 1'b0};
      srR   <= newSr;
      spR   <= spIn;
      diffR <= diffNew;
      trapR <= trapNew;
    end else if (stb.step) begin
      spR   <= memAddr;
      diffR <= diffR + DIFFW'(1);
    end
  end

  assign memAddr   = spR - XLEN'(4);
  assign lregIdx   = memAddr[IDXW+1:2];
  assign lregData  = memRspData;
  assign pcOut     = pcR;
  assign srOut     = srR;
  assign spOut     = spR;
  assign stat.trap = trapR;
  assign stat.neg  = diffR[DIFFW-1];
  assign stat.last = (diffR == {DIFFW{1'b1}});

  // R7: every refill step lowers the stack pointer by one word
  assert_sp_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> spOut == $past(spOut) - XLEN'(4));
endmodule

// File: rtl/ret_ctrl.sv
module ret_ctrl
  import ret_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  status_t stat,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output strobe_t stb,
  output logic    memReqValid,
  output logic    lregWe,
  output logic    busy,
  output logic    done,
  output logic    trap
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_REQ, S_WAIT, S_FIN} state_t;
  state_t state, stateNx;

  always_comb begin
    stateNx  = state;
    stb      = '0;
    case (state)
      S_IDLE: if (start && stat.isRet) begin
        stb.load = 1'b1;
        stateNx  = S_CHECK;
      end
      S_CHECK: stateNx = (stat.trap || !stat.neg) ? S_FIN : S_REQ;
      S_REQ:   if (memReqReady) stateNx = S_WAIT;
      S_WAIT:  if (memRspValid) begin
        stb.step = 1'b1;
        stateNx  = stat.last ? S_FIN : S_REQ;
      end
      S_FIN:   stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNx;
  end

  assign memReqValid = (state == S_REQ);
  assign lregWe      = (state == S_WAIT) && memRspValid;
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign trap        = done && stat.trap;

  // R7: a pending request stays up until accepted
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);
  // R5: a trap is only reported with done
  assert_trap_with_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> done);
  // R2: a non-return word issued while idle starts nothing
  assert_no_move_double_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && !stat.isRet && !busy |=> !busy);
  // R8: done lasts one cycle and leaves the block idle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
endmodule

// File: rtl/ret_unit.sv
module ret_unit
  import ret_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DIFFW = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [15:0]      instr,
  output logic [4:0]       pairIdx,
  input  logic [XLEN-1:0]  regHi,
  input  logic [XLEN-1:0]  regLo,
  input  logic             curS,
  input  logic             curL,
  input  logic [DIFFW-1:0] fpIn,
  input  logic [XLEN-1:0]  spIn,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [XLEN-1:0]  memAddr,
  input  logic             memRspValid,
  input  logic [XLEN-1:0]  memRspData,
  output logic             lregWe,
  output logic [DIFFW-2:0] lregIdx,
  output logic [XLEN-1:0]  lregData,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  srOut,
  output logic [XLEN-1:0]  spOut,
  output logic             busy,
  output logic             done,
  output logic             trap
);
  strobe_t stb;
  status_t stat;

  ret_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .stb(stb), .memReqValid(memReqValid), .lregWe(lregWe),
    .busy(busy), .done(done), .trap(trap)
  );

  ret_dpath #(.XLEN(XLEN), .DIFFW(DIFFW)) u_dpath (
    .clk(clk), .rstN(rstN), .instr(instr), .regHi(regHi), .regLo(regLo),
    .curS(curS), .curL(curL), .fpIn(fpIn), .spIn(spIn), .stb(stb),
    .memRspData(memRspData), .stat(stat), .pairIdx(pairIdx),
    .pcOut(pcOut), .srOut(srOut), .spOut(spOut), .memAddr(memAddr),
    .lregIdx(lregIdx), .lregData(lregData)
  );
endmodule

// File: tb/sim_ret_unit.sv
`timescale 1ns/1ps
module sim_ret_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [4:0]  pairIdx;
  logic [31:0] regHi = '0, regLo = '0, spIn = '0;
  logic        curS = 1'b0, curL = 1'b0;
  logic [6:0]  fpIn = '0;
  logic        memReqValid, memRspValid = 1'b0;
  logic        memReqReady = 1'b1;
  logic [31:0] memAddr, memRspData = '0;
  logic        lregWe;
  logic [5:0]  lregIdx;
  logic [31:0] lregData, pcOut, srOut, spOut;
  logic        busy, done, trap;

  ret_unit u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] actL [64];
  logic [31:0] expL [64];

  typedef struct {
    logic [31:0] pc, sr, sp;
    logic        trap;
    int          doneCyc;
    string       tag;
  } item_t;
  item_t sbq[$];

  function automatic logic [31:0] memFn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= memReqValid && memReqReady;
    memRspData  <= memFn(memAddr);
    if (lregWe) actL[lregIdx] <= lregData;
  end

  // driver: predict, queue, issue
  task automatic issueRet(string tag, logic sBit, logic [3:0] srcCode,
                          logic [31:0] hi, logic [31:0] lo, logic oS, logic oL,
                          logic [6:0] fp, logic [31:0] sp);
    item_t it;
    logic [31:0] nsr, s;
    logic [6:0]  d;
    logic        tr;
    int          n;
    nsr = lo; nsr[18] = hi[0]; nsr[20:19] = 2'b00;
    tr  = (!oS && hi[0]) || (!hi[0] && !oL && lo[15]);
    d   = fp - sp[8:2];
    n   = (!tr && d[6]) ? (128 - int'(d)) : 0;
    s   = sp;
    for (int i = 0; i < n; i++) begin
      s = s - 32'd4;
      expL[s[7:2]] = memFn(s);
    end
    it.pc = {hi[31:1], 1'b0}; it.sr = nsr; it.sp = s; it.trap = tr;
    it.doneCyc = cyc + 2 + 2 * n; it.tag = tag;
    @(negedge clk);
    it.doneCyc = cyc + 2 + 2 * n;
    sbq.push_back(it);
    instr = {6'b000001, 1'b0, sBit, 4'd0, srcCode};
    regHi = hi; regLo = lo; curS = oS; curL = oL; fpIn = fp; spIn = sp;
    start = 1'b1;
    #1;
    check(pairIdx == {sBit, srcCode}, "R1 pairIdx", 32'(pairIdx), 32'({sBit, srcCode}));
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare at done
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        bit regOk;
        it = sbq.pop_front();
        check(pcOut == it.pc, {"R3 pc ", it.tag}, pcOut, it.pc);
        check(srOut == it.sr, {"R4 sr ", it.tag}, srOut, it.sr);
        check(spOut == it.sp, {"R7 sp ", it.tag}, spOut, it.sp);
        check(trap == it.trap, {"R5 trap ", it.tag}, 32'(trap), 32'(it.trap));
        check(cyc == it.doneCyc, {"R8/R6 latency ", it.tag}, cyc, it.doneCyc);
        regOk = 1'b1;
        for (int k = 0; k < 64; k++) if (actL[k] !== expL[k]) regOk = 1'b0;
        check(regOk, {"R7 local regs ", it.tag}, 32'(regOk), 32'd1);
      end
    end
  end

  task automatic checkIgnored(string tag, logic [15:0] w);
    logic [31:0] pc0;
    pc0 = pcOut;
    @(negedge clk);
    instr = w; regHi = 32'hDEAD_BEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy, {"R2 busy ", tag}, 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    check(!busy && pcOut == pc0, {"R2 outputs ", tag}, pcOut, pc0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin actL[k] = '0; expL[k] = '0; end
    repeat (3) @(negedge clk);
    check(!busy && !done && !trap && !memReqValid && !lregWe, "R9 reset ctrl",
          {27'd0, busy, done, trap, memReqValid, lregWe}, 32'd0);
    check(pcOut == 0 && srOut == 0 && spOut == 0, "R9 reset regs", pcOut | srOut | spOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // positive difference: 10 - 5
    issueRet("dpos", 1'b0, 4'd2, 32'h1000_0041, 32'h0018_8123, 1'b1, 1'b0, 7'd10, 32'd20);
    // zero difference
    issueRet("dzero", 1'b0, 4'd4, 32'h2000_0001, 32'h0000_0000, 1'b1, 1'b0, 7'd8, 32'd32);
    // -1
    issueRet("dm1", 1'b1, 4'd6, 32'h3000_0011, 32'h7F00_0000, 1'b1, 1'b1, 7'd7, 32'd32);
    // -3 with local source set
    issueRet("dm3", 1'b1, 4'd9, 32'h4000_0020, 32'h00FF_FFFF, 1'b1, 1'b0, 7'd2, 32'h0000_0414);
    // wrapped difference: 2 - 100 reads as positive
    issueRet("dwrap", 1'b0, 4'd1, 32'h4400_0001, 32'h0, 1'b1, 1'b0, 7'd2, 32'd400);
    // most negative: 0 - 64
    issueRet("dmin", 1'b0, 4'd3, 32'h5000_0001, 32'h0001_0000, 1'b1, 1'b0, 7'd0, 32'd256);
    // trap S 0->1 despite negative difference
    issueRet("trapS", 1'b0, 4'd5, 32'h6000_0001, 32'h0000_0000, 1'b0, 1'b0, 7'd0, 32'd40);
    // trap L 0->1 while user
    issueRet("trapL", 1'b0, 4'd5, 32'h6100_0000, 32'h0000_8000, 1'b0, 1'b0, 7'd20, 32'd40);
    // no trap: L already set
    issueRet("noTrapL", 1'b0, 4'd5, 32'h6200_0000, 32'h0000_8000, 1'b0, 1'b1, 7'd20, 32'd40);

    // R10: second start while busy is ignored
    fork
      issueRet("busyIgn", 1'b0, 4'd7, 32'h7000_0001, 32'h0, 1'b1, 1'b0, 7'd0, 32'd16);
      begin
        repeat (3) @(negedge clk);
        instr = 16'h0400; regHi = 32'h0BAD_0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join

    // R2: move double-word and foreign opcode
    checkIgnored("dstG3", 16'b000001_0_0_0011_0010);
    checkIgnored("dstL0", 16'b000001_1_0_0000_0010);
    checkIgnored("opc", 16'b000010_0_0_0000_0010);

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R8 all returns done", 32'(sbq.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule